// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block keeps the bus-off state of a CAN controller and walks it back to normal operation. It watches the transmit error count. When that count reaches the limit (256), the block takes the node off the bus, clears the software-initialisation flag and raises a one-cycle error-interrupt request.

To recover, the node must count recessive bits. These are sampled bits qualified by a single-cycle bit strobe. The node needs 128 runs of 11 consecutive recessive bits, followed by one further 11-bit run as a power-up phase. A dominant bit restarts only the run in progress.

On completion the block leaves bus-off and pulses a clear to both external error counters. It also sets the software-initialisation flag. Transmit and receive stay disabled until software writes that flag back to 0. Software writes to the flag are locked out for as long as the node is bus-off.

Top module: `can_busoff_seq`

## Requirements
- R1: After a synchronous active-low reset: `busoff_o`=0, `swinit_o`=0, `bus_en_o`=1, `ecnt_clr_o`=0, `err_irq_o`=0. All recessive-bit counts are zero.
- R2: When not bus-off, a transmit error count `tec_i` of 256 or more sets `busoff_o`=1 and `swinit_o`=0 at the next clock edge. This holds even if a software write arrives in the same cycle. Counts below 256 have no effect.
- R3: `err_irq_o` is high for exactly one cycle, the first cycle in which `busoff_o` reads 1. It does not repeat while bus-off persists.
- R4: `bus_en_o` is 1 only when `busoff_o`=0 and `swinit_o`=0.
- R5: A software write (`sw_we_i`=1) is ignored in any cycle in which `busoff_o` is 1. This includes the cycle in which recovery completes.
- R6: Only a cycle with `bit_stb_i`=1 advances recessive-bit counting. With `rx_bit_i`=1 (recessive) the run grows. With `rx_bit_i`=0 (dominant) the run restarts from zero. Cycles without the strobe change nothing.
- R7: The first recovery phase needs 128 completed runs of 11 consecutive recessive bits. A dominant bit does not reduce the number of runs already completed.
- R8: After the 128th run, a power-up run of 11 further consecutive recessive bits is required. A dominant bit restarts this run only.
- R9: At the clock edge that takes the final power-up bit, these outputs change together: `busoff_o` goes to 0, `swinit_o` goes to 1, and `ecnt_clr_o` pulses high for exactly that one following cycle.
- R10: While not bus-off, a software write loads `sw_wdata_i` into `swinit_o` at the next edge.
- R11: `tec_i` is ignored in the cycle in which `ecnt_clr_o` is high. The external counters clear on the edge that ends the pulse, so the stale count must not cause a new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tec_i | input | TEC_W (9) | Transmit error count |
| bit_stb_i | input | 1 | Single-cycle strobe marking a sampled bus bit |
| rx_bit_i | input | 1 | Sampled bus bit, 1 = recessive, 0 = dominant |
| sw_we_i | input | 1 | Software write strobe for the initialisation flag |
| sw_wdata_i | input | 1 | Value written to the initialisation flag |
| busoff_o | output | 1 | Node is bus-off |
| swinit_o | output | 1 | Software-initialisation flag |
| bus_en_o | output | 1 | Transmit and receive enable |
| ecnt_clr_o | output | 1 | One-cycle clear for both error counters |
| err_irq_o | output | 1 | One-cycle error-interrupt request on bus-off entry |

## Verification
A software write to the initialisation flag can land in the same cycle as a bus-off entry, or in the same cycle as the strobe carrying the last power-up bit. The bench provokes both by driving `sw_we_i` together with the limit count, and together with the final recessive strobe. In both cases the hardware must win: after entry the flag reads 0, and after recovery it reads 1 with the write lost. A third collision, a stale limit count during the counter-clear cycle, is driven on purpose and must not send the node back to bus-off.

// File: rtl/bo_pkg.sv
// Package: shared types for the bus-off recovery sequencer.
// Assumes: nothing beyond the standard language.
package bo_pkg;

    // Recovery phase of the node.
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,   // on the bus or waiting for software
        PH_GROUPS = 2'd1,   // counting runs of recessive bits
        PH_PWRUP  = 2'd2    // counting the power-up run
    } bo_phase_e;

endpackage

// File: rtl/bo_run_counter.sv
// Module: counts consecutive recessive bits and pulses when a run of
// RUN_LEN is complete; the count then starts again from zero.
// Assumes: bit_stb_i is high for one cycle per bus bit; while enable_i is
// low the count is held at zero.
module bo_run_counter #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic bit_stb_i,
    input  logic recessive_i,
    output logic run_done_o
);
    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    // Flag the final bit of a run.
    always_comb begin
        at_last    = (cnt_q == LAST);
        run_done_o = enable_i && bit_stb_i && recessive_i && at_last;
    end

    // Advance, restart or hold the run length.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            cnt_q <= '0;
        end else if (bit_stb_i) begin
            if (!recessive_i || at_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6: without a strobe the run length stays put.
    p_run_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !bit_stb_i) |=> $stable(cnt_q));

endmodule

// File: rtl/bo_group_counter.sv
// Module: counts completed recessive runs during the first recovery phase.
// Assumes: inc_i is a one-cycle pulse; clear_i has priority over inc_i.
module bo_group_counter #(
    parameter int GROUPS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam logic [GW-1:0] LAST = GW'(GROUPS - 1);

    logic [GW-1:0] cnt_q;

    // Tell the controller when the next run is the final one.
    always_comb begin
        last_o = (cnt_q == LAST);
    end

    // Keep the number of runs completed so far.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R7: a dominant bit (no increment) leaves completed runs untouched.
    p_group_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !inc_i) |=> $stable(cnt_q));

endmodule

// File: rtl/bo_ctrl.sv
// Module: phase controller. Enters bus-off on the limit count, steps
// through the run and power-up phases, and owns the software flag, the
// counter clear and the interrupt request.
// Assumes: the error counters clear on the edge that ends ecnt_clr_o.
module bo_ctrl
    import bo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tec_full_i,
    input  logic run_done_i,
    input  logic group_last_i,
    input  logic sw_we_i,
    input  logic sw_wdata_i,
    output logic busoff_o,
    output logic swinit_o,
    output logic bus_en_o,
    output logic ecnt_clr_o,
    output logic err_irq_o,
    output logic run_en_o,
    output logic group_inc_o,
    output logic group_clr_o
);
    bo_phase_e phase_q, phase_d;
    logic      swinit_q, clr_q, irq_q;
    logic      enter, leave;

    // Decide entry, exit and the next phase.
    always_comb begin
        enter   = (phase_q == PH_ACTIVE) && tec_full_i && !clr_q;
        leave   = (phase_q == PH_PWRUP) && run_done_i;
        phase_d = phase_q;
        unique case (phase_q)
            PH_ACTIVE: if (enter) phase_d = PH_GROUPS;
            PH_GROUPS: if (run_done_i && group_last_i) phase_d = PH_PWRUP;
            PH_PWRUP:  if (run_done_i) phase_d = PH_ACTIVE;
            default:   phase_d = PH_ACTIVE;
        endcase
    end

    // Hold the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_ACTIVE;
        else        phase_q <= phase_d;
    end

    // Software flag: hardware events win; writes only while on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                               swinit_q <= 1'b0;
        else if (enter)                           swinit_q <= 1'b0;
        else if (leave)                           swinit_q <= 1'b1;
        else if (sw_we_i && phase_q == PH_ACTIVE) swinit_q <= sw_wdata_i;
    end

    // One-cycle clear and interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            clr_q <= leave;
            irq_q <= enter;
        end
    end

    // Drive outputs and counter controls.
    always_comb begin
        busoff_o    = (phase_q != PH_ACTIVE);
        swinit_o    = swinit_q;
        bus_en_o    = (phase_q == PH_ACTIVE) && !swinit_q;
        ecnt_clr_o  = clr_q;
        err_irq_o   = irq_q;
        run_en_o    = (phase_q != PH_ACTIVE);
        group_inc_o = (phase_q == PH_GROUPS) && run_done_i;
        group_clr_o = (phase_q != PH_GROUPS);
    end

    // R2: limit count while on the bus leads to bus-off with flag low.
    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_o && tec_full_i && !ecnt_clr_o) |=> (busoff_o && !swinit_o));

    // R3: the request coincides with the first bus-off cycle.
    p_irq_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> (busoff_o && !$past(busoff_o)));

    // R5: the flag cannot be raised by software while bus-off.
    p_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_o |-> !swinit_o);

    // R9: the clear pulse follows the bus-off exit with the flag set.
    p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt_clr_o |-> (!busoff_o && swinit_o && $past(busoff_o)));

    // R11: no re-entry straight after the clear pulse.
    p_no_reentry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt_clr_o |=> !busoff_o);

endmodule

// File: rtl/can_busoff_seq.sv
// Module: top of the bus-off recovery sequencer. Compares the transmit
// error count with the limit and ties the run counter, the group counter
// and the phase controller together.
// Assumes: rx_bit_i is valid whenever bit_stb_i is high; 1 = recessive.
module can_busoff_seq #(
    parameter int TEC_W     = 9,
    parameter int TEC_LIMIT = 256,
    parameter int RUN_LEN   = 11,
    parameter int GROUPS    = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TEC_W-1:0] tec_i,
    input  logic             bit_stb_i,
    input  logic             rx_bit_i,
    input  logic             sw_we_i,
    input  logic             sw_wdata_i,
    output logic             busoff_o,
    output logic             swinit_o,
    output logic             bus_en_o,
    output logic             ecnt_clr_o,
    output logic             err_irq_o
);
    localparam logic [TEC_W-1:0] LIMIT = TEC_W'(TEC_LIMIT);

    logic tec_full, run_en, run_done, group_inc, group_clr, group_last;

    // Limit comparison on the transmit error count.
    always_comb begin
        tec_full = (tec_i >= LIMIT);
    end

    bo_run_counter #(.RUN_LEN(RUN_LEN)) i_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (run_en),
        .bit_stb_i   (bit_stb_i),
        .recessive_i (rx_bit_i),
        .run_done_o  (run_done)
    );

    bo_group_counter #(.GROUPS(GROUPS)) i_group (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (group_clr),
        .inc_i   (group_inc),
        .last_o  (group_last)
    );

    bo_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tec_full_i   (tec_full),
        .run_done_i   (run_done),
        .group_last_i (group_last),
        .sw_we_i      (sw_we_i),
        .sw_wdata_i   (sw_wdata_i),
        .busoff_o     (busoff_o),
        .swinit_o     (swinit_o),
        .bus_en_o     (bus_en_o),
        .ecnt_clr_o   (ecnt_clr_o),
        .err_irq_o    (err_irq_o),
        .run_en_o     (run_en),
        .group_inc_o  (group_inc),
        .group_clr_o  (group_clr)
    );

    // R4: enable only on the bus with the software flag low.
    p_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o |-> (!busoff_o && !swinit_o));

endmodule

// File: tb/test_can_busoff_seq.sv
// Bench: table of write/entry vectors, then directed recovery and reset tests.
module test_can_busoff_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] tec = '0;
    logic       stb = 1'b0, rx = 1'b1, we = 1'b0, wd = 1'b0;
    logic       busoff, swinit, bus_en, clr, irq;
    int         n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    can_busoff_seq i_can_busoff_seq (
        .clk(clk), .rst_n(rst_n), .tec_i(tec), .bit_stb_i(stb),
        .rx_bit_i(rx), .sw_we_i(we), .sw_wdata_i(wd),
        .busoff_o(busoff), .swinit_o(swinit), .bus_en_o(bus_en),
        .ecnt_clr_o(clr), .err_irq_o(irq)
    );

    // Vector: [15:7] tec, [6] we, [5] wdata, [4:0] expected {busoff,swinit,en,clr,irq}
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{
        {9'd0,   1'b1, 1'b1, 5'b01000},  // R10 write 1
        {9'd0,   1'b1, 1'b0, 5'b00100},  // R10 R4 write 0
        {9'd255, 1'b0, 1'b0, 5'b00100},  // R2 below limit
        {9'd256, 1'b1, 1'b1, 5'b10001},  // R2 R3 entry beats write
        {9'd0,   1'b1, 1'b1, 5'b10000},  // R5 R3 locked write, no repeat
        {9'd300, 1'b0, 1'b0, 5'b10000}   // R2 stays bus-off
    };
    localparam int VREQ [NV] = '{10, 10, 2, 2, 5, 2};

    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {busoff, swinit, bus_en, clr, irq};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {busoff,swinit,en,clr,irq} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle of stimulus: drive at negedge, sample at following negedge.
    task automatic cyc(input logic [8:0] t, input logic s, input logic r,
                       input logic w, input logic d);
        tec = t; stb = s; rx = r; we = w; wd = d;
        @(negedge clk);
        stb = 1'b0; we = 1'b0;
    endtask

    task automatic bits(input int n, input logic r);
        for (int i = 0; i < n; i++) cyc(tec, 1'b1, r, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset", 5'b00100);

        for (int v = 0; v < NV; v++) begin
            cyc(VEC[v][15:7], 1'b0, 1'b1, VEC[v][6], VEC[v][5]);
            chk($sformatf("R%0d vector %0d", VREQ[v], v), VEC[v][4:0]);
        end

        // Recovery with restarts. tec held at the limit throughout.
        tec = 9'd256;
        bits(5, 1'b1);
        bits(1, 1'b0);                       // R6 restart
        for (int i = 0; i < 10; i++) cyc(tec, 1'b0, 1'b1, 1'b0, 1'b0);
        bits(700, 1'b1);                     // 63 runs + 7 bits
        bits(1, 1'b0);                       // R7 runs kept
        chk("R7 mid groups", 5'b10000);
        bits(715, 1'b1);                     // runs 64..128 done
        chk("R7 groups done, power-up pending", 5'b10000);
        bits(5, 1'b1);
        bits(1, 1'b0);                       // R8 power-up restart
        bits(10, 1'b1);
        chk("R8 one bit short", 5'b10000);
        for (int i = 0; i < 3; i++) cyc(tec, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R6 no strobe no count", 5'b10000);
        cyc(tec, 1'b1, 1'b1, 1'b1, 1'b0);    // final bit with write 0
        chk("R9 R5 exit, write lost", 5'b01010);
        cyc(9'd256, 1'b0, 1'b1, 1'b0, 1'b0); // stale count in clear cycle
        chk("R11 R9 no re-entry, pulse ends", 5'b01000);
        cyc(9'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R10 R4 software release", 5'b00100);

        // Reset from bus-off.
        cyc(9'd256, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 re-entry request", 5'b10001);
        rst_n = 1'b0;
        cyc(9'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        chk("R1 reset from bus-off", 5'b00100);
        bits(11, 1'b1);
        chk("R1 counting idle when on bus", 5'b00100);

        finish_run();
    end
endmodule